// File: doc/BRIEF.md
# Round-trip propagation delay estimator

This block measures the one-way propagation delay to one neighbour while a network of timing nodes is being set up. Both nodes run the same block, one as initiator and one as responder. The initiator clears its local timer and fires its transmitter in the same cycle. The responder listens for the correlation peak of that burst. On the peak it clears its own timer and fires its transmitter back at once. When the initiator sees the reply peak, it adds the external timer value to a running sum. After sixteen good trials it writes one result into a delay memory, at the address of the neighbour index. A later correction stage uses that memory when it compares measured arrival times against the learned delays.

The stored value is one-way. It is the mean round trip, with a programmable turnaround latency taken away, and then halved. Every wait for a reply is limited by a programmable timeout. A trial that gets no reply in time is retried. When the total number of failed windows reaches a fixed budget, the measurement is dropped with an error pulse and nothing is written. The responder side uses the same window and the same failure budget while it waits for each peak.

Top module: `rtd_est`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `tx_go`, `tmr_clr`, `mem_we`, `done` and `err` are all low.
- R2: A `start` seen while idle with `role`=0 (initiator) gives exactly one cycle, the next one, in which `tx_go` and `tmr_clr` are both high. In the initiator role, a later trial fires in the same way: its single firing cycle follows the reply or the timeout that ended the previous trial.
- R3: In the initiator role, the wait window opens in the cycle after a firing cycle. A `peak` inside the window adds the `timer_val` of that cycle to the sum and ends the trial.
- R4: On the sixteenth successful reply, the next cycle has `mem_we` and `done` high for exactly one cycle. In that cycle `mem_addr` is the neighbour index and `mem_data` is `(floor(sum/16) - turn_lat) >> 1`. When `floor(sum/16) < turn_lat`, `mem_data` is 0.
- R5: The wait window lasts `timeout` cycles. If no `peak` arrives in it, the trial fails and adds nothing to the sum, and a new firing cycle follows at once. A `peak` that falls in a firing cycle is ignored.
- R6: A `peak` in the last cycle of the window, the `timeout`-th cycle after the firing cycle, counts as a success and not as a timeout.
- R7: When the number of failed windows in one measurement reaches MAXF (default 4), in either role, the next cycle has `err` high for one cycle. No `mem_we` is given, and the block goes back to idle.
- R8: In the responder role (`role`=1), a `peak` while waiting drives `tx_go` and `tmr_clr` high in that same cycle. After sixteen peaks, `done` is high for one cycle and `mem_we` stays low.
- R9: `start` while a measurement runs has no effect. A `peak` while idle does not transmit.
- R10: The neighbour index is latched on the accepted `start`. Later changes of `nbr_idx` do not change `mem_addr` for that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role | input | 1 | 0 initiator, 1 responder; sampled at start |
| nbr_idx | input | NW | Neighbour index; sampled at start |
| start | input | 1 | Start strobe; ignored when busy |
| peak | input | 1 | Peak-detect strobe from the correlator |
| timer_val | input | TW | Value of the local timer |
| turn_lat | input | TW | Fixed turnaround latency to remove |
| timeout | input | TW | Reply window length in cycles |
| tx_go | output | 1 | Transmit trigger |
| tmr_clr | output | 1 | Local timer clear |
| mem_we | output | 1 | Delay memory write enable |
| mem_addr | output | NW | Delay memory address |
| mem_data | output | TW | One-way delay to write |
| done | output | 1 | Measurement finished pulse |
| err | output | 1 | Measurement aborted pulse |

## Verification
A reply peak and the end of a wait window can fall in the same cycle. The bench provokes this with a reply latency equal to `timeout`, so the peak lands in the last window cycle. That trial must count as a success, and its timer value must show up in the written delay. A latency one cycle longer puts the peak into the retry's firing cycle, where it must be ignored. The written value is checked against a sum worked out from the list of latencies alone. In the responder role, a gap one cycle longer than the window makes a timeout and a peak fall in neighbouring cycles. The failure count is then judged from the gap list.

// File: rtl/rtd_pkg.sv
package rtd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRE,
        ST_WAIT,
        ST_WRITE,
        ST_FAIL,
        ST_RWAIT,
        ST_RDONE
    } rtd_state_t;

    typedef enum logic {
        ROLE_INIT = 1'b0,
        ROLE_RESP = 1'b1
    } rtd_role_t;

    // events seen while a reply window is open
    typedef struct packed {
        logic hit;
        logic miss;
        logic final_hit;
        logic final_miss;
    } rtd_evt_t;

endpackage

// File: rtl/rtd_window.sv
module rtd_window #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          last
);

    logic [TW-1:0] wcnt;

    // true in the final cycle of a window of `limit` cycles
    assign last = ({1'b0, wcnt} + {{TW{1'b0}}, 1'b1}) >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            wcnt <= '0;
        end else if (run && !last) begin
            wcnt <= wcnt + 1'b1;
        end
    end

endmodule

// File: rtl/rtd_accum.sv
module rtd_accum #(
    parameter int TW   = 16,
    parameter int LOGN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          add,
    input  logic [TW-1:0] sample,
    input  logic [TW-1:0] turn,
    output logic [TW-1:0] one_way
);

    localparam int AW = TW + LOGN;

    logic [AW-1:0] acc;
    logic [TW-1:0] avg;
    logic [TW-1:0] diff;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc <= '0;
        end else if (add) begin
            acc <= acc + {{LOGN{1'b0}}, sample};
        end
    end

    // mean by dropping LOGN bits, then turnaround removal with floor at zero
    assign avg = acc[AW-1:LOGN];

    always_comb begin
        if (avg >= turn) begin
            diff = avg - turn;
        end else begin
            diff = '0;
        end
        one_way = diff >> 1;
    end

endmodule

// File: rtl/rtd_ctrl.sv
module rtd_ctrl
    import rtd_pkg::*;
#(
    parameter int NW   = 3,
    parameter int LOGN = 4,
    parameter int MAXF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  rtd_role_t     role,
    input  logic          peak,
    input  logic          last,
    input  logic [NW-1:0] nbr_in,
    output logic          tx_go,
    output logic          acc_clear,
    output logic          acc_add,
    output logic          win_restart,
    output logic          win_run,
    output logic          mem_we,
    output logic          done,
    output logic          err,
    output logic [NW-1:0] nbr_q
);

    localparam int FW = (MAXF < 2) ? 1 : $clog2(MAXF);
    localparam logic [FW-1:0]   FAIL_TOP = FW'(MAXF - 1);
    localparam logic [LOGN-1:0] OK_TOP   = '1;

    rtd_state_t    st, st_nx;
    logic [LOGN-1:0] ok_cnt;
    logic [FW-1:0]   fail_cnt;
    rtd_evt_t      ev;
    logic          waiting;
    logic          accept;

    assign waiting = (st == ST_WAIT) || (st == ST_RWAIT);
    assign accept  = (st == ST_IDLE) && start;

    always_comb begin
        ev.hit        = waiting && peak;
        ev.miss       = waiting && !peak && last;
        ev.final_hit  = ev.hit && (ok_cnt == OK_TOP);
        ev.final_miss = ev.miss && (fail_cnt == FAIL_TOP);
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = (role == ROLE_RESP) ? ST_RWAIT : ST_FIRE;
            ST_FIRE:  st_nx = ST_WAIT;
            ST_WAIT: begin
                if (ev.final_hit)       st_nx = ST_WRITE;
                else if (ev.hit)        st_nx = ST_FIRE;
                else if (ev.final_miss) st_nx = ST_FAIL;
                else if (ev.miss)       st_nx = ST_FIRE;
            end
            ST_RWAIT: begin
                if (ev.final_hit)       st_nx = ST_RDONE;
                else if (ev.final_miss) st_nx = ST_FAIL;
            end
            ST_WRITE, ST_FAIL, ST_RDONE: st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ok_cnt   <= '0;
            fail_cnt <= '0;
            nbr_q    <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                ok_cnt   <= '0;
                fail_cnt <= '0;
                nbr_q    <= nbr_in;
            end else begin
                if (ev.hit)  ok_cnt   <= ok_cnt + 1'b1;
                if (ev.miss) fail_cnt <= fail_cnt + 1'b1;
            end
        end
    end

    assign tx_go       = (st == ST_FIRE) || ((st == ST_RWAIT) && peak);
    assign acc_clear   = accept;
    assign acc_add     = (st == ST_WAIT) && peak;
    assign win_restart = accept || (st == ST_FIRE) || ((st == ST_RWAIT) && (peak || last));
    assign win_run     = waiting;
    assign mem_we      = (st == ST_WRITE);
    assign done        = (st == ST_WRITE) || (st == ST_RDONE);
    assign err         = (st == ST_FAIL);

    AST_FIRE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start && role == ROLE_INIT) |=> tx_go); // R2

    AST_ERR_AFTER_MISS: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(ev.miss)); // R7

    AST_NBR_HELD: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> $stable(nbr_q)); // R10

    AST_ADD_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        acc_add |-> win_run); // R3

endmodule

// File: rtl/rtd_est.sv
module rtd_est
    import rtd_pkg::*;
#(
    parameter int TW   = 16,
    parameter int NW   = 3,
    parameter int LOGN = 4,
    parameter int MAXF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          role,
    input  logic [NW-1:0] nbr_idx,
    input  logic          start,
    input  logic          peak,
    input  logic [TW-1:0] timer_val,
    input  logic [TW-1:0] turn_lat,
    input  logic [TW-1:0] timeout,
    output logic          tx_go,
    output logic          tmr_clr,
    output logic          mem_we,
    output logic [NW-1:0] mem_addr,
    output logic [TW-1:0] mem_data,
    output logic          done,
    output logic          err
);

    logic acc_clear, acc_add, win_restart, win_run, win_last;
    logic fire;

    rtd_ctrl #(.NW(NW), .LOGN(LOGN), .MAXF(MAXF)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .role        (rtd_role_t'(role)),
        .peak        (peak),
        .last        (win_last),
        .nbr_in      (nbr_idx),
        .tx_go       (fire),
        .acc_clear   (acc_clear),
        .acc_add     (acc_add),
        .win_restart (win_restart),
        .win_run     (win_run),
        .mem_we      (mem_we),
        .done        (done),
        .err         (err),
        .nbr_q       (mem_addr)
    );

    rtd_window #(.TW(TW)) u_win (
        .clk     (clk),
        .rst     (rst),
        .restart (win_restart),
        .run     (win_run),
        .limit   (timeout),
        .last    (win_last)
    );

    rtd_accum #(.TW(TW), .LOGN(LOGN)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clear   (acc_clear),
        .add     (acc_add),
        .sample  (timer_val),
        .turn    (turn_lat),
        .one_way (mem_data)
    );

    // both roles clear the local timer in the cycle they transmit
    assign tx_go   = fire;
    assign tmr_clr = fire;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R4

    AST_WE_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> done); // R4

    AST_NO_WE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && err)); // R7

endmodule

// File: tb/sim_rtd_est.sv
module sim_rtd_est;

    localparam int TW = 16, NW = 3, LOGN = 4, MAXF = 4, NTRIAL = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          role = 1'b0;
    logic [NW-1:0] nbr_idx = '0;
    logic          start = 1'b0;
    logic          peak = 1'b0;
    logic [TW-1:0] timer_val = '0;
    logic [TW-1:0] turn_lat = '0;
    logic [TW-1:0] timeout = 16'd20;
    logic          tx_go, tmr_clr, mem_we, done, err;
    logic [NW-1:0] mem_addr;
    logic [TW-1:0] mem_data;

    rtd_est #(.TW(TW), .NW(NW), .LOGN(LOGN), .MAXF(MAXF)) u0 (
        .clk(clk), .rst(rst), .role(role), .nbr_idx(nbr_idx), .start(start),
        .peak(peak), .timer_val(timer_val), .turn_lat(turn_lat), .timeout(timeout),
        .tx_go(tx_go), .tmr_clr(tmr_clr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .done(done), .err(err)
    );

    int    checks = 0, errors = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference: 0 idle, 1 firing, 2 waiting, 3 writing, 4 error, 5 listening, 6 responder done
    int m_st = 0, m_ok = 0, m_fail = 0, m_w = 0, m_sum = 0, m_nbr = 0;
    // stimulus emulation
    int lat_q[$];
    int gap_q[$];
    int sc[$];
    int cd = 0, tnext = 0;
    bit resp_mode = 0, idle_pk = 0;
    int nwe = 0, ndone = 0, nerr = 0, got_addr = 0, got_data = 0;

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s got %0d exp %0d", cur_req, what, got, exp);
        end
    endtask

    function automatic int one_way(input int sum, input int turn);
        int avg;
        avg = sum / NTRIAL;
        return (avg >= turn) ? (avg - turn) / 2 : 0;
    endfunction

    task automatic step(input logic s);
        logic pk;
        int   e_tx, e_we, e_done, e_err, tmo;
        @(negedge clk);
        start = s;
        pk = 1'b0;
        if (cd > 0) begin
            cd--;
            pk = (cd == 0);
        end
        if (pk && resp_mode && gap_q.size() > 0) cd = gap_q.pop_front();
        pk = pk | idle_pk;
        peak = pk;
        timer_val = TW'(tnext);
        #1;
        e_tx   = (!rst && (m_st == 1 || (m_st == 5 && pk))) ? 1 : 0;
        e_we   = (!rst && m_st == 3) ? 1 : 0;
        e_done = (!rst && (m_st == 3 || m_st == 6)) ? 1 : 0;
        e_err  = (!rst && m_st == 4) ? 1 : 0;
        chk("tx_go", int'(tx_go), e_tx);
        chk("tmr_clr", int'(tmr_clr), e_tx);
        chk("mem_we", int'(mem_we), e_we);
        chk("done", int'(done), e_done);
        chk("err", int'(err), e_err);
        if (e_we == 1) begin
            chk("mem_addr", int'(mem_addr), m_nbr);
            chk("mem_data", int'(mem_data), one_way(m_sum, int'(turn_lat)));
        end
        if (mem_we) begin
            nwe++;
            got_addr = int'(mem_addr);
            got_data = int'(mem_data);
        end
        if (done) ndone++;
        if (err) nerr++;
        if (tx_go && !resp_mode) begin
            if (lat_q.size() > 0) begin
                int l;
                l = lat_q.pop_front();
                cd = (l > 0) ? l : 0;
            end else begin
                cd = 0;
            end
        end
        tnext = tmr_clr ? 0 : int'(timer_val) + 1;
        tmo = int'(timeout);
        if (rst) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: if (s) begin
                    m_nbr = int'(nbr_idx); m_ok = 0; m_fail = 0; m_sum = 0; m_w = 0;
                    m_st = role ? 5 : 1;
                end
                1: begin m_st = 2; m_w = 0; end
                2: begin
                    if (pk) begin
                        m_sum += int'(timer_val);
                        m_ok++;
                        m_st = (m_ok == NTRIAL) ? 3 : 1;
                    end else if (m_w >= tmo - 1) begin
                        m_fail++;
                        m_st = (m_fail == MAXF) ? 4 : 1;
                    end else m_w++;
                end
                5: begin
                    if (pk) begin
                        m_ok++; m_w = 0;
                        if (m_ok == NTRIAL) m_st = 6;
                    end else if (m_w >= tmo - 1) begin
                        m_fail++; m_w = 0;
                        if (m_fail == MAXF) m_st = 4;
                    end else m_w++;
                end
                default: m_st = 0;
            endcase
        end
    endtask

    // initiator run; latencies count cycles from the firing cycle to the reply peak, -1 for none
    task automatic run_init(input string req, input int nbr, input int tmo, input int turn, input bit poke);
        int sum, ok, fails;
        cur_req = req;
        role = 1'b0; nbr_idx = NW'(nbr); timeout = TW'(tmo); turn_lat = TW'(turn);
        resp_mode = 0; lat_q = sc; cd = 0; nwe = 0; ndone = 0; nerr = 0;
        step(1'b1);
        for (int i = 0; i < 3000 && m_st != 0; i++) begin
            if (poke && i == 9) nbr_idx = NW'(nbr + 1);   // R10 change after latch
            step(poke && (i == 7 || i == 30));            // R9 start while busy
        end
        start = 1'b0;
        repeat (20) step(1'b0);
        sum = 0; ok = 0; fails = 0;
        foreach (sc[k]) begin
            if (ok < NTRIAL && fails < MAXF) begin
                if (sc[k] >= 1 && sc[k] <= tmo) begin sum += sc[k] - 1; ok++; end
                else fails++;
            end
        end
        if (ok == NTRIAL) begin
            chk("write count", nwe, 1);
            chk("written addr", got_addr, nbr);
            chk("written delay", got_data, one_way(sum, turn));
            chk("err count", nerr, 0);
        end else begin
            chk("write count", nwe, 0);
            chk("err count", nerr, 1);
        end
    endtask

    // responder run; gaps count cycles from start (or previous peak) to the next peak
    task automatic run_resp(input string req, input int tmo);
        int ok, fails, g0;
        cur_req = req;
        role = 1'b1; timeout = TW'(tmo); resp_mode = 1; nwe = 0; ndone = 0; nerr = 0;
        cd = 0; idle_pk = 1; step(1'b0); idle_pk = 0;    // R9 peak while idle
        gap_q = sc;
        g0 = gap_q.pop_front();
        cd = g0 + 1;
        step(1'b1);
        for (int i = 0; i < 3000 && m_st != 0; i++) step(1'b0);
        repeat (60) step(1'b0);
        ok = 0; fails = 0;
        foreach (sc[k]) begin
            if (ok < NTRIAL && fails < MAXF) begin
                fails += (sc[k] - 1) / tmo;
                if (fails < MAXF) ok++;
            end
        end
        chk("write count", nwe, 0);
        chk("done count", ndone, (ok == NTRIAL) ? 1 : 0);
        chk("err count", nerr, (ok == NTRIAL) ? 0 : 1);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) step(1'b0);
        rst = 1'b0;
        step(1'b0);   // R1 first cycle out of reset

        // R3 R4 R6 R9 R10: two latencies equal the window (peak on last cycle)
        sc = '{5, 9, 20, 12, 7, 3, 18, 20, 1, 6, 11, 14, 2, 19, 8, 10};
        run_init("R6", 5, 20, 2, 1'b1);

        // R5: no reply, and a reply one cycle late landing in the retry firing cycle
        sc = '{-1, 4, 9, 6, 5, 7, 8, 3, 2, 8, 6, 4, 5, 7, 3, 2, 1, 8};
        run_init("R5", 2, 8, 0, 1'b0);

        // R7: failure budget used up in the initiator role
        sc = '{-1, 3, -1, 12, -1, 5, 5};
        run_init("R7", 6, 8, 0, 1'b0);

        // R4: turnaround larger than the mean gives zero
        sc = '{10, 10, 10, 10, 10, 10, 10, 10, 10, 10, 10, 10, 10, 10, 10, 10};
        run_init("R4", 7, 20, 50, 1'b0);

        // R2 after the earlier runs: fresh start fires once, next cycle
        sc = '{3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3, 3};
        run_init("R2", 1, 4, 1, 1'b0);

        // R8: responder, one gap one cycle past the window
        sc = '{3, 1, 10, 5, 2, 11, 4, 7, 1, 9, 6, 3, 8, 2, 5, 10};
        run_resp("R8", 10);

        // R7: responder runs out of its failure budget
        sc = '{2, 50};
        run_resp("R7", 6);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL %s watchdog got %0d exp %0d", cur_req, 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule